// File: doc/BRIEF.md
# Elastic Bit-Store Jitter Smoother

This block evens out the timing of a 1.544 Mb/s serial bit stream inside one master clock domain. The master clock runs at sixteen times the line rate. Input bits arrive with a single-cycle write strobe whose spacing may wander, jitter, or come in gaps and bursts. The bits are parked in an elastic single-bit store and drained by a read strobe. That read strobe comes from a divider that normally fires once every sixteen master cycles.

When the fill of the store drifts too far from its mid point, the divider runs one short period of fifteen cycles or one long period of seventeen cycles. This pulls the fill back toward the middle. Each such steering period also sets a sticky limit-trip flag.

Three static controls shape the block:
- The store depth is 32 bits for low delay or 128 bits for heavy wander.
- The input is taken from either the receive (recovered) stream or the transmit stream.
- A bypass control passes the selected input strobe and bit straight to the output, one register late.

Top module: `jitter_smoother`

## Requirements
- R1: After reset, `sm_stb` and `limit_trip` are 0. The first output strobe is seen 16 cycles after reset is released, and it carries the fill value 1.
- R2: With input bits arriving once every 16 cycles and the fill near the mid point, output strobes are exactly 16 cycles apart and `limit_trip` stays 0.
- R3: Output bits appear in input order. They come after depth/2 preloaded fill bits, and the fill value is 1.
- R4: When a read decision sees a fill above depth/2 plus the threshold, the next output period is 15 cycles and `limit_trip` becomes 1.
- R5: When a read decision sees a fill below depth/2 minus the threshold, the next output period is 17 cycles and `limit_trip` becomes 1.
- R6: The threshold is 14 bits in 32-bit mode (`cfg_deep`=0), giving limits above 30 and below 2. It is 60 bits in 128-bit mode (`cfg_deep`=1), giving limits above 124 and below 4.
- R7: `cfg_txpath`=0 takes `rxr_stb`/`rxr_dat`, and `cfg_txpath`=1 takes `txs_stb`/`txs_dat`. Strobes on the input that is not selected have no effect on the output stream.
- R8: With `cfg_bypass`=1, each selected input strobe appears on `sm_stb` one cycle later, with `sm_dat` equal to the input bit.
- R9: `limit_trip` is sticky and is cleared one cycle after a `trip_clr` pulse. When a set and a clear fall in the same cycle, the flag ends up 1.
- R10: `sm_dat` changes only in a cycle where `sm_stb` is 1.
- R11: A change of `cfg_deep` re-centres the store like a reset does. The read side restarts depth/2 bits behind the write side, and all earlier contents are replaced by fill bits.
- R12: A write into a full store with no read in the same cycle is dropped, and stored bits are not overwritten. A read from an empty store outputs the fill value 1 and does not move the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 16x line rate |
| rst | input | 1 | Synchronous active-high reset |
| rxr_stb | input | 1 | Receive-path bit strobe |
| rxr_dat | input | 1 | Receive-path bit |
| txs_stb | input | 1 | Transmit-path bit strobe (may be gapped) |
| txs_dat | input | 1 | Transmit-path bit |
| cfg_deep | input | 1 | 0: 32-bit store, 1: 128-bit store |
| cfg_txpath | input | 1 | 0: receive input, 1: transmit input |
| cfg_bypass | input | 1 | 1: pass selected input straight through |
| trip_clr | input | 1 | One-cycle clear for the limit flag |
| sm_stb | output | 1 | Smoothed output strobe |
| sm_dat | output | 1 | Output bit, valid with `sm_stb` |
| limit_trip | output | 1 | Sticky flag for a 15- or 17-cycle period |

## Verification
The assertions assume that `cfg_bypass` and `cfg_txpath` change only while the block is idle. They also assume that the selected write strobe is at most one bit per cycle. A change of `cfg_deep` is treated as a re-centring event and not as a fault.

The stimulus changes the path and bypass controls only under reset or between phases. Bursts are at most one bit per master cycle. Steering is provoked on purpose by bursting past the upper limit, or by starving the store until it drains below the lower limit.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

    // One input beat: strobe plus the bit it carries
    typedef struct packed {
        logic stb;
        logic dat;
    } bit_beat_t;

    // Length chosen for the next output period
    typedef enum logic [1:0] {
        STEER_NOM  = 2'd0,
        STEER_FAST = 2'd1,
        STEER_SLOW = 2'd2
    } steer_e;

    // Pick the next divider period from the fill level
    function automatic steer_e pick_steer(input logic [15:0] fill,
                                          input logic [15:0] half,
                                          input logic [15:0] thr);
        if (fill > half + thr)      return STEER_FAST;
        else if (fill < half - thr) return STEER_SLOW;
        else                        return STEER_NOM;
    endfunction

endpackage

// File: rtl/jsm_bitstore.sv
module jsm_bitstore
    import jsm_pkg::*;
#(
    parameter int   DEPTH_SMALL = 32,
    parameter int   DEPTH_LARGE = 128,
    parameter logic FILL_BIT    = 1'b1,
    localparam int  PTR_W       = $clog2(DEPTH_LARGE),
    localparam int  CNT_W       = $clog2(DEPTH_LARGE + 1)
) (
    input  logic             clk,
    input  logic             reinit,
    input  logic             deep,
    input  bit_beat_t        wr,
    input  logic             rd_en,
    output logic             rd_bit,
    output logic [CNT_W-1:0] fill
);
    logic [DEPTH_LARGE-1:0] mem;
    logic [PTR_W-1:0]       wr_ptr, rd_ptr, ptr_mask;
    logic [CNT_W-1:0]       depth_now, half_now;
    logic                   do_rd, do_wr;

    assign depth_now = deep ? CNT_W'(DEPTH_LARGE)   : CNT_W'(DEPTH_SMALL);
    assign ptr_mask  = deep ? PTR_W'(DEPTH_LARGE-1) : PTR_W'(DEPTH_SMALL-1);
    assign half_now  = depth_now >> 1;
    assign do_rd     = rd_en && (fill != '0);
    assign do_wr     = wr.stb && ((fill != depth_now) || do_rd);
    assign rd_bit    = (fill != '0) ? mem[rd_ptr] : FILL_BIT;

    always_ff @(posedge clk) begin
        if (reinit) begin
            mem    <= {DEPTH_LARGE{FILL_BIT}};
            rd_ptr <= '0;
            wr_ptr <= PTR_W'(half_now);
            fill   <= half_now;
        end else begin
            if (do_wr) begin
                mem[wr_ptr] <= wr.dat;
                wr_ptr      <= (wr_ptr + 1'b1) & ptr_mask;
            end
            if (do_rd)
                rd_ptr <= (rd_ptr + 1'b1) & ptr_mask;
            fill <= fill + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    // R12: the fill never passes the selected depth
    assert_fill_bound_R12: assert property (@(posedge clk) disable iff (reinit)
        fill <= depth_now);

    // R12: a write into a full store without a read leaves the fill unchanged
    assert_full_drop_R12: assert property (@(posedge clk) disable iff (reinit)
        (wr.stb && !rd_en && fill == depth_now) |=> (fill == $past(fill) || reinit));

endmodule

// File: rtl/jsm_rate_div.sv
module jsm_rate_div
    import jsm_pkg::*;
#(
    parameter int  DEPTH_SMALL = 32,
    parameter int  DEPTH_LARGE = 128,
    parameter int  THR_SMALL   = 14,
    parameter int  THR_LARGE   = 60,
    parameter int  DIV_NOM     = 16,
    localparam int CNT_W       = $clog2(DEPTH_LARGE + 1),
    localparam int DIV_W       = $clog2(DIV_NOM + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reinit,
    input  logic             deep,
    input  logic [CNT_W-1:0] fill,
    input  logic             trip_clr,
    output logic             rd_stb,
    output logic             trip
);
    logic [DIV_W-1:0] cnt;
    logic [15:0]      half_w, thr_w;
    steer_e           steer;
    logic             trip_set;

    assign half_w   = deep ? 16'(DEPTH_LARGE / 2) : 16'(DEPTH_SMALL / 2);
    assign thr_w    = deep ? 16'(THR_LARGE) : 16'(THR_SMALL);
    assign steer    = pick_steer(16'(fill), half_w, thr_w);
    assign rd_stb   = (cnt == '0) && !reinit;
    assign trip_set = rd_stb && (steer != STEER_NOM);

    always_ff @(posedge clk) begin
        if (reinit) begin
            cnt <= DIV_W'(DIV_NOM - 1);
        end else if (cnt == '0) begin
            unique case (steer)
                STEER_FAST: cnt <= DIV_W'(DIV_NOM - 2);
                STEER_SLOW: cnt <= DIV_W'(DIV_NOM);
                default:    cnt <= DIV_W'(DIV_NOM - 1);
            endcase
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           trip <= 1'b0;
        else if (trip_set) trip <= 1'b1;
        else if (trip_clr) trip <= 1'b0;
    end

    // R4: a read decision above the upper limit raises the flag
    assert_fast_trip_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && 16'(fill) > half_w + thr_w) |=> trip);

    // R5: a read decision below the lower limit raises the flag
    assert_slow_trip_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && 16'(fill) < half_w - thr_w) |=> trip);

    // R9: a clear with no read decision in that cycle drops the flag
    assert_trip_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (trip_clr && !rd_stb) |=> !trip);

endmodule

// File: rtl/jitter_smoother.sv
module jitter_smoother
    import jsm_pkg::*;
#(
    parameter int   DEPTH_SMALL = 32,
    parameter int   DEPTH_LARGE = 128,
    parameter int   THR_SMALL   = 14,
    parameter int   THR_LARGE   = 60,
    parameter int   DIV_NOM     = 16,
    parameter logic FILL_BIT    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic rxr_stb,
    input  logic rxr_dat,
    input  logic txs_stb,
    input  logic txs_dat,
    input  logic cfg_deep,
    input  logic cfg_txpath,
    input  logic cfg_bypass,
    input  logic trip_clr,
    output logic sm_stb,
    output logic sm_dat,
    output logic limit_trip
);
    localparam int CNT_W = $clog2(DEPTH_LARGE + 1);

    bit_beat_t        sel, store_wr;
    logic             deep_q, reinit, rd_stb, rd_bit;
    logic [CNT_W-1:0] fill;

    assign sel      = cfg_txpath ? '{stb: txs_stb, dat: txs_dat}
                                 : '{stb: rxr_stb, dat: rxr_dat};
    assign store_wr = '{stb: sel.stb && !cfg_bypass, dat: sel.dat};
    assign reinit   = rst || (cfg_deep != deep_q);

    always_ff @(posedge clk) begin
        if (rst) deep_q <= cfg_deep;
        else     deep_q <= cfg_deep;
    end

    jsm_bitstore #(
        .DEPTH_SMALL (DEPTH_SMALL),
        .DEPTH_LARGE (DEPTH_LARGE),
        .FILL_BIT    (FILL_BIT)
    ) u_store (
        .clk    (clk),
        .reinit (reinit),
        .deep   (cfg_deep),
        .wr     (store_wr),
        .rd_en  (rd_stb),
        .rd_bit (rd_bit),
        .fill   (fill)
    );

    jsm_rate_div #(
        .DEPTH_SMALL (DEPTH_SMALL),
        .DEPTH_LARGE (DEPTH_LARGE),
        .THR_SMALL   (THR_SMALL),
        .THR_LARGE   (THR_LARGE),
        .DIV_NOM     (DIV_NOM)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .reinit   (reinit),
        .deep     (cfg_deep),
        .fill     (fill),
        .trip_clr (trip_clr),
        .rd_stb   (rd_stb),
        .trip     (limit_trip)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sm_stb <= 1'b0;
            sm_dat <= FILL_BIT;
        end else if (cfg_bypass) begin
            sm_stb <= sel.stb;
            if (sel.stb) sm_dat <= sel.dat;
        end else begin
            sm_stb <= rd_stb;
            if (rd_stb) sm_dat <= rd_bit;
        end
    end

    // R10: the output bit holds between strobes
    assert_dat_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !sm_stb |-> $stable(sm_dat));

    // R8: in bypass a selected strobe reappears one cycle later with its bit
    assert_bypass_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_bypass && sel.stb) |=> (sm_stb && sm_dat == $past(sel.dat)));

endmodule

// File: tb/jitter_smoother_tb.sv
module jitter_smoother_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rxr_stb = 0, rxr_dat = 0, txs_stb = 0, txs_dat = 0;
    logic cfg_deep = 0, cfg_txpath = 0, cfg_bypass = 0, trip_clr = 0;
    logic sm_stb, sm_dat, limit_trip;

    int   errors = 0, checks = 0, cycles = 0, stab_err = 0, since = 0;
    bit   sb_on = 0, gap_chk = 0, have_prev = 0, done = 0;
    logic prev_bit;
    logic exp_q[$];

    always #2.5 clk = ~clk;

    jitter_smoother u_dut (
        .clk(clk), .rst(rst),
        .rxr_stb(rxr_stb), .rxr_dat(rxr_dat),
        .txs_stb(txs_stb), .txs_dat(txs_dat),
        .cfg_deep(cfg_deep), .cfg_txpath(cfg_txpath), .cfg_bypass(cfg_bypass),
        .trip_clr(trip_clr),
        .sm_stb(sm_stb), .sm_dat(sm_dat), .limit_trip(limit_trip)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: scoreboard pops, strobe spacing and hold checks
    always @(negedge clk) begin
        cycles++;
        if (rst) begin
            have_prev = 0;
            since     = 0;
            prev_bit  = sm_dat;
        end else begin
            if (!sm_stb && sm_dat !== prev_bit) stab_err++;
            prev_bit = sm_dat;
            since++;
            if (sm_stb) begin
                if (gap_chk && have_prev) chk(since == 16, "R2 period", since, 16);
                have_prev = 1;
                since     = 0;
                if (sb_on && exp_q.size() > 0) begin
                    logic e;
                    e = exp_q.pop_front();
                    chk(sm_dat == e, "R3 order", int'(sm_dat), int'(e));
                end
            end
        end
    end

    // Watchdog
    always @(negedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            chk(0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        exp_q.delete();
        if (sb_on) for (int k = 0; k < 16; k++) exp_q.push_back(1'b1);
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    // One bit on the selected path, then idle; optional noise on the other path
    task automatic send(input logic b, input int idle, input bit noise);
        @(negedge clk);
        if (cfg_txpath) begin txs_stb = 1; txs_dat = b; end
        else            begin rxr_stb = 1; rxr_dat = b; end
        if (sb_on) exp_q.push_back(b);
        @(negedge clk);
        txs_stb = 0; rxr_stb = 0;
        for (int k = 0; k < idle; k++) begin
            if (noise && k == 6) begin
                if (cfg_txpath) begin rxr_stb = 1; rxr_dat = 0; end
                else            begin txs_stb = 1; txs_dat = 0; end
            end
            @(negedge clk);
            txs_stb = 0; rxr_stb = 0;
        end
    endtask

    // Back-to-back writes on the receive path; only the first n_push go to the scoreboard
    task automatic burst(input int n, input int n_push);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            rxr_stb = 1;
            rxr_dat = (k % 3 == 0);
            if (sb_on && k < n_push) exp_q.push_back(logic'(k % 3 == 0));
            @(negedge clk);
        end
        rxr_stb = 0;
    endtask

    task automatic wait_stb();
        @(negedge clk);
        while (!sm_stb) @(negedge clk);
    endtask

    task automatic measure_gap(output int g);
        wait_stb();
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!sm_stb);
    endtask

    initial begin
        int  g;
        int  n;
        bit  seen;

        // R1: reset state and first strobe timing
        do_reset();
        chk(sm_stb == 0, "R1 stb after reset", sm_stb, 0);
        chk(limit_trip == 0, "R1 trip after reset", limit_trip, 0);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sm_stb && n < 40);
        chk(n == 16, "R1 first strobe", n, 16);
        chk(sm_dat == 1, "R1 fill bit", sm_dat, 1);

        // R2, R3, R7: receive path with transmit-side noise
        sb_on = 1; cfg_txpath = 0;
        do_reset();
        gap_chk = 1;
        for (int i = 0; i < 24; i++) send(logic'(((i * 5 + 3) % 7) > 3), 14, 1);
        gap_chk = 0;
        chk(limit_trip == 0, "R2 no trip", limit_trip, 0);
        n = 0;
        while (exp_q.size() > 0 && n < 800) begin @(negedge clk); n++; end
        chk(exp_q.size() == 0, "R3 drained", exp_q.size(), 0);

        // R7: transmit path with receive-side noise
        cfg_txpath = 1;
        do_reset();
        for (int i = 0; i < 24; i++) send(logic'(((i * 3 + 1) % 5) > 1), 14, 1);
        n = 0;
        while (exp_q.size() > 0 && n < 800) begin @(negedge clk); n++; end
        chk(exp_q.size() == 0, "R7 tx path stream", exp_q.size(), 0);
        cfg_txpath = 0;

        // R12: overflow writes dropped; only the safely accepted bits are scored
        do_reset();
        burst(24, 16);
        n = 0;
        while (exp_q.size() > 0 && n < 800) begin @(negedge clk); n++; end
        chk(exp_q.size() == 0, "R12 no overwrite", exp_q.size(), 0);
        sb_on = 0;

        // R4: burst above the upper limit, then R9 clear
        do_reset();
        burst(17, 0);
        measure_gap(g);
        chk(g == 15, "R4 fast period", g, 15);
        chk(limit_trip == 1, "R4 trip set", limit_trip, 1);
        measure_gap(g);
        trip_clr = 1;
        @(negedge clk);
        trip_clr = 0;
        chk(limit_trip == 0, "R9 clear", limit_trip, 0);

        // R9: set wins over a held clear
        do_reset();
        trip_clr = 1;
        seen = 0;
        fork
            burst(17, 0);
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (limit_trip) seen = 1;
            end
        join
        trip_clr = 0;
        chk(seen == 1, "R9 set wins", seen, 1);

        // R5, R6, R12: starve the store
        do_reset();
        repeat (200) @(negedge clk);
        chk(limit_trip == 0, "R6 low limit 2 not yet", limit_trip, 0);
        n = 0;
        while (!limit_trip && n < 300) begin @(negedge clk); n++; end
        measure_gap(g);
        chk(g == 17, "R5 slow period", g, 17);
        chk(limit_trip == 1, "R5 trip set", limit_trip, 1);
        chk(sm_dat == 1, "R12 empty read fill", sm_dat, 1);

        // R11, R6: zeros stored in 32-bit mode, then switch to 128-bit mode
        do_reset();
        for (int i = 0; i < 16; i++) send(1'b0, 14, 0);
        @(negedge clk);
        cfg_deep = 1;
        n = 0;
        fork
            burst(56, 0);
            for (int k = 0; k < 64; k++) begin
                wait_stb();
                if (sm_dat != 1) n++;
            end
        join
        chk(n == 0, "R11 recentred fill bits", n, 0);
        chk(limit_trip == 0, "R6 deep no trip", limit_trip, 0);
        measure_gap(g);
        chk(g == 16, "R6 deep nominal", g, 16);
        burst(90, 0);
        measure_gap(g);
        chk(g == 15, "R6 deep fast", g, 15);
        chk(limit_trip == 1, "R6 deep trip", limit_trip, 1);
        cfg_deep = 0;

        // R8: bypass on the transmit path, irregular spacing
        cfg_bypass = 1; cfg_txpath = 1;
        do_reset();
        for (int i = 0; i < 6; i++) begin
            logic b;
            b = logic'(i % 2);
            @(negedge clk);
            txs_stb = 1; txs_dat = b;
            @(negedge clk);
            txs_stb = 0;
            chk(sm_stb == 1 && sm_dat == b, "R8 bypass", int'({sm_stb, sm_dat}), int'({1'b1, b}));
            repeat (i) @(negedge clk);
            @(negedge clk);
            chk(sm_stb == 0, "R8 bypass idle", sm_stb, 0);
        end
        cfg_bypass = 0;

        chk(stab_err == 0, "R10 hold", stab_err, 0);
        done = 1;
        finish_run();
    end
endmodule